// File: doc/BRIEF.md
# Single-Cycle Delayed-Branch RISC Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It executes a small integer instruction set: load word, store word, register-register add, subtract, AND, OR and signed set-on-less-than, compare-equal branch, and absolute jump. Every instruction is decoded, executed and retired in the cycle in which it is fetched. The register file, program counter and the caller's data memory all update on the rising edge.

Both memories live outside the core. The instruction port presents a byte address and expects the addressed 32-bit word back in the same cycle. The data port presents an address, write data and separate read and write strobes, and expects the read word back combinationally. Control transfers are delayed by one instruction. The word that follows a branch or jump always executes, and control moves to the target afterwards. For this reason the core keeps two registers, a current fetch address and a next fetch address.

Instruction fields: opcode in bits 31:26, first source register in 25:21, second source/load destination in 20:16, R-type destination in 15:11, function code in 5:0, 16-bit offset in 15:0, 26-bit jump field in 25:0.

Top module: `sdc_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, the fetch address is 0. After the first rising edge it is 4.
- R2: When neither the current instruction nor the one before it is a branch or jump, the next fetch address is the current one plus 4.
- R3: Opcode 0x23 (load) drives the data address to base register (bits 25:21) plus the sign-extended offset (bits 15:0). It raises the read strobe and writes the returned word into the register named by bits 20:16. The read strobe is high for no other opcode.
- R4: Opcode 0x2B (store) drives the same address form and raises the write strobe with the value of register bits 20:16 as write data. The write strobe is high for no other opcode.
- R5: Opcode 0 with function code 0x20, 0x22, 0x24 or 0x25 writes the sum, difference (rs minus rt), bitwise AND or bitwise OR of registers rs and rt into register rd (bits 15:11).
- R6: Opcode 0 with function code 0x2A writes 1 into rd when rs is less than rt as signed numbers, and writes 0 otherwise.
- R7: Register 0 reads as zero, and any write aimed at it is discarded.
- R8: Opcode 0x04 compares rs and rt. The following instruction always executes. If the two were equal, the fetch after that one is the branch address plus 4 plus the sign-extended offset times 4; if they differed, execution continues in sequence.
- R9: Opcode 0x02 always executes the following instruction, then fetches from the upper 4 bits of (jump address plus 4) joined with the 26-bit field times 4.
- R10: Any other opcode, or opcode 0 with any other function code, changes no register and no memory and advances in sequence.
- R11: The data read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Data byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| dmem_re | output | 1 | Load strobe |
| dmem_we | output | 1 | Store strobe; the memory writes on the rising edge |

## Verification
The checker assumes that imem_rdata always carries the word at the address currently driven on imem_addr. It decodes the opcode straight from that port, and its program-counter properties rely on the memory answering within the same cycle. It also assumes that no branch or jump sits in the delay slot of another, because the slot-step property only covers a transfer whose predecessor was not itself a transfer. The bench models both memories as combinational arrays indexed by imem_addr and dmem_addr. It runs a fixed program that places only ordinary instructions or no-ops in every delay slot, and ends in a two-word loop whose branch has a negative offset.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   localparam int unsigned INSN_W = 32;

   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLT = 3'd4
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rd;
      logic    mem_re;
      logic    mem_we;
      logic    use_imm;
      logic    is_beq;
      logic    is_jmp;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
   import sdc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opcode)
         OP_RTYPE: begin
            ctrl.dst_rd = 1'b1;
            unique case (funct)
               FN_ADD:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
               FN_SUB:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
               FN_AND:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
               FN_OR:   begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
               FN_SLT:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
               default: ctrl.reg_we = 1'b0;
            endcase
         end
         OP_LOAD: begin
            ctrl.reg_we  = 1'b1;
            ctrl.mem_re  = 1'b1;
            ctrl.use_imm = 1'b1;
         end
         OP_STORE: begin
            ctrl.mem_we  = 1'b1;
            ctrl.use_imm = 1'b1;
         end
         OP_BEQ: begin
            ctrl.is_beq = 1'b1;
            ctrl.alu_op = ALU_SUB;
         end
         OP_JUMP: ctrl.is_jmp = 1'b1;
         default: ctrl.reg_we = 1'b0;
      endcase
   end

endmodule

// File: rtl/sdc_alu.sv
module sdc_alu
   import sdc_pkg::*;
#(
   parameter int unsigned W            = 32,
   parameter bit          SLT_FROM_SUB = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);

   logic [W-1:0] sum;
   logic [W-1:0] diff;
   logic         lt;

   assign sum  = a + b;
   assign diff = a - b;

   generate
      if (SLT_FROM_SUB) begin : g_slt_sub
         logic ovf;
         assign ovf = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
         assign lt  = diff[W-1] ^ ovf;
      end else begin : g_slt_cmp
         assign lt = $signed(a) < $signed(b);
      end
   endgenerate

   always_comb begin
      unique case (op)
         ALU_ADD: y = sum;
         ALU_SUB: y = diff;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = sum;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sdc_regfile.sv
module sdc_regfile #(
   parameter int unsigned W        = 32,
   parameter int unsigned NREGS    = 32,
   parameter bit          ZERO_REG = 1'b1,
   localparam int unsigned AW      = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata
);

   logic [W-1:0] regs [NREGS];
   logic         wr_ok;

   assign wr_ok = we && !(ZERO_REG && (waddr == '0));

   always_ff @(posedge clk) begin
      if (wr_ok) regs[waddr] <= wdata;
   end

   generate
      if (ZERO_REG) begin : g_zero
         assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
         assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
      end else begin : g_plain
         assign rdata_a = regs[raddr_a];
         assign rdata_b = regs[raddr_b];
      end
   endgenerate

endmodule

// File: rtl/sdc_nextpc.sv
module sdc_nextpc #(
   parameter int unsigned          W        = 32,
   parameter logic [W-1:0]         RESET_PC = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         take,
   input  logic [W-1:0] target,
   output logic [W-1:0] pc
);

   localparam logic [W-1:0] STEP = W'(4);

   logic [W-1:0] pc_q;
   logic [W-1:0] npc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= RESET_PC;
         npc_q <= RESET_PC + STEP;
      end else begin
         pc_q  <= npc_q;
         npc_q <= take ? target : (npc_q + STEP);
      end
   end

   assign pc = pc_q;

endmodule

// File: rtl/sdc_core.sv
module sdc_core
   import sdc_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NREGS        = 32,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          ZERO_REG     = 1'b1,
   parameter bit          SLT_FROM_SUB = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   input  logic [31:0] dmem_rdata,
   output logic        dmem_re,
   output logic        dmem_we
);

   localparam int unsigned AW = $clog2(NREGS);

   generate
      if (XLEN != INSN_W) begin : g_bad_xlen
         $error("sdc_core: XLEN must equal the 32-bit instruction width");
      end
      if (NREGS != 32) begin : g_bad_nregs
         $error("sdc_core: the 5-bit register fields require NREGS of 32");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("sdc_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0] pc;
   logic [XLEN-1:0] pc_plus4;
   logic [XLEN-1:0] imm_sx;
   logic [XLEN-1:0] br_target;
   logic [XLEN-1:0] jmp_target;
   logic [XLEN-1:0] xfer_target;
   logic            take;
   ctrl_t           ctrl;
   logic [XLEN-1:0] rs_val;
   logic [XLEN-1:0] rt_val;
   logic [XLEN-1:0] alu_b;
   logic [XLEN-1:0] alu_y;
   logic            alu_zero;
   logic [AW-1:0]   wr_addr;
   logic [XLEN-1:0] wr_data;

   sdc_decode u_dec (
      .opcode (imem_rdata[31:26]),
      .funct  (imem_rdata[5:0]),
      .ctrl   (ctrl)
   );

   sdc_regfile #(
      .W        (XLEN),
      .NREGS    (NREGS),
      .ZERO_REG (ZERO_REG)
   ) u_rf (
      .clk     (clk),
      .raddr_a (imem_rdata[21 +: AW]),
      .raddr_b (imem_rdata[16 +: AW]),
      .rdata_a (rs_val),
      .rdata_b (rt_val),
      .we      (ctrl.reg_we),
      .waddr   (wr_addr),
      .wdata   (wr_data)
   );

   assign imm_sx = {{(XLEN-16){imem_rdata[15]}}, imem_rdata[15:0]};
   assign alu_b  = ctrl.use_imm ? imm_sx : rt_val;

   sdc_alu #(
      .W            (XLEN),
      .SLT_FROM_SUB (SLT_FROM_SUB)
   ) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .op   (ctrl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign wr_addr = ctrl.dst_rd ? imem_rdata[11 +: AW] : imem_rdata[16 +: AW];
   assign wr_data = ctrl.mem_re ? dmem_rdata : alu_y;

   assign pc_plus4    = pc + XLEN'(4);
   assign br_target   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
   assign jmp_target  = {pc_plus4[XLEN-1:28], imem_rdata[25:0], 2'b00};
   assign take        = (ctrl.is_beq && alu_zero) || ctrl.is_jmp;
   assign xfer_target = ctrl.is_jmp ? jmp_target : br_target;

   sdc_nextpc #(
      .W        (XLEN),
      .RESET_PC (RESET_PC)
   ) u_npc (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .target (xfer_target),
      .pc     (pc)
   );

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rt_val;
   assign dmem_re    = ctrl.mem_re;
   assign dmem_we    = ctrl.mem_we;

endmodule

// File: rtl/sdc_core_chk.sv
module sdc_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] imem_addr,
   input logic [5:0]  op,
   input logic [4:0]  rs_field,
   input logic [31:0] rs_val,
   input logic        dmem_re,
   input logic        dmem_we
);

   logic xfer_now;
   logic prev_xfer;

   assign xfer_now = (op == 6'h04) || (op == 6'h02);

   always_ff @(posedge clk) begin
      if (!rst_n) prev_xfer <= 1'b0;
      else        prev_xfer <= xfer_now;
   end

   a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_now && !prev_xfer) |=> (imem_addr == $past(imem_addr) + 32'd4));

   a_r8_slot_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_now && !prev_xfer) |=> (imem_addr == $past(imem_addr) + 32'd4));

   a_r3_read_only_load: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_re |-> (op == 6'h23));

   a_r4_write_only_store: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> (op == 6'h2B));

   a_r7_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_field == 5'd0) |-> (rs_val == 32'd0));

   a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(dmem_re && dmem_we));

endmodule

bind sdc_core sdc_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imem_addr (imem_addr),
   .op        (imem_rdata[31:26]),
   .rs_field  (imem_rdata[25:21]),
   .rs_val    (rs_val),
   .dmem_re   (dmem_re),
   .dmem_we   (dmem_we)
);

// File: tb/sdc_core_bench.sv
module sdc_core_bench;

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      string       req;
   } st_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_re, dmem_we;

   logic [31:0] imem [64];
   logic [31:0] dmem [64];
   st_item_t    exp_q [$];
   int          total = 0;
   int          bad   = 0;

   always #5 clk = ~clk;

   sdc_core u_sdc_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_rdata (dmem_rdata),
      .dmem_re    (dmem_re),
      .dmem_we    (dmem_we)
   );

   assign imem_rdata = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

   function automatic logic [31:0] r_ins(input logic [5:0] fn, input int rs, input int rt, input int rd);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_store(input logic [31:0] a, input logic [31:0] d, input string req);
      st_item_t it;
      it.addr = a; it.data = d; it.req = req;
      exp_q.push_back(it);
   endtask

   // monitor: store events against the scoreboard, load strobe per cycle (R3, R11)
   always @(negedge clk) begin
      if (rst_n) begin
         check("R3 read strobe", {31'd0, dmem_re}, {31'd0, imem_rdata[31:26] == 6'h23});
         check("R11 strobe overlap", {31'd0, dmem_re && dmem_we}, 32'd0);
         if (dmem_we) begin
            if (exp_q.size() == 0) begin
               check("R4/R8/R9 unexpected store address", dmem_addr, 32'hFFFF_FFFF);
            end else begin
               st_item_t it;
               it = exp_q.pop_front();
               check({it.req, " store address"}, dmem_addr, it.addr);
               check({it.req, " store data"}, dmem_wdata, it.data);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin imem[i] = 32'd0; dmem[i] = 32'd0; end
      dmem[0] = 32'd5; dmem[1] = 32'd7; dmem[2] = 32'hFFFF_FFFD;
      imem[0]  = i_ins(6'h23, 0, 1, 16'd0);
      imem[1]  = i_ins(6'h23, 0, 2, 16'd4);
      imem[2]  = i_ins(6'h23, 0, 3, 16'd8);
      imem[3]  = r_ins(6'h20, 1, 2, 4);
      imem[4]  = i_ins(6'h2B, 0, 4, 16'd64);
      imem[5]  = r_ins(6'h22, 1, 2, 5);
      imem[6]  = i_ins(6'h2B, 0, 5, 16'd68);
      imem[7]  = r_ins(6'h24, 1, 2, 6);
      imem[8]  = i_ins(6'h2B, 0, 6, 16'd72);
      imem[9]  = r_ins(6'h25, 1, 2, 7);
      imem[10] = i_ins(6'h2B, 0, 7, 16'd76);
      imem[11] = r_ins(6'h2A, 3, 1, 8);
      imem[12] = r_ins(6'h2A, 1, 3, 9);
      imem[13] = i_ins(6'h2B, 0, 8, 16'd80);
      imem[14] = i_ins(6'h2B, 0, 9, 16'd84);
      imem[15] = r_ins(6'h20, 1, 2, 0);
      imem[16] = i_ins(6'h2B, 0, 0, 16'd88);
      imem[17] = i_ins(6'h04, 1, 2, 16'd10);
      imem[18] = i_ins(6'h2B, 0, 1, 16'd92);
      imem[19] = i_ins(6'h2B, 0, 2, 16'd96);
      imem[20] = i_ins(6'h04, 1, 1, 16'd3);
      imem[21] = i_ins(6'h2B, 0, 4, 16'd100);
      imem[22] = i_ins(6'h2B, 0, 5, 16'd104);
      imem[23] = i_ins(6'h2B, 0, 5, 16'd104);
      imem[24] = i_ins(6'h23, 4, 10, 16'hFFFC);
      imem[25] = i_ins(6'h2B, 0, 10, 16'd108);
      imem[26] = {6'h02, 26'd30};
      imem[27] = i_ins(6'h2B, 0, 7, 16'd112);
      imem[28] = i_ins(6'h2B, 0, 6, 16'd116);
      imem[29] = i_ins(6'h2B, 0, 6, 16'd116);
      imem[30] = i_ins(6'h08, 0, 1, 16'h0033);
      imem[31] = i_ins(6'h2B, 0, 1, 16'd116);
      imem[32] = i_ins(6'h04, 0, 0, 16'hFFFF);
      imem[33] = 32'd0;

      push_store(32'd64,  32'd12,          "R5 add");
      push_store(32'd68,  32'hFFFF_FFFE,   "R5 sub");
      push_store(32'd72,  32'd5,           "R5 and");
      push_store(32'd76,  32'd7,           "R5 or");
      push_store(32'd80,  32'd1,           "R6 slt true");
      push_store(32'd84,  32'd0,           "R6 slt false");
      push_store(32'd88,  32'd0,           "R7 zero register");
      push_store(32'd92,  32'd5,           "R8 slot after untaken");
      push_store(32'd96,  32'd7,           "R8 untaken fallthrough");
      push_store(32'd100, 32'd12,          "R8 slot after taken");
      push_store(32'd108, 32'hFFFF_FFFD,   "R3 negative offset load");
      push_store(32'd112, 32'd7,           "R9 jump slot");
      push_store(32'd116, 32'd5,           "R10 unknown opcode no-op");

      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 fetch address in reset", imem_addr, 32'd0);
      rst_n = 1'b1;
      #1 check("R1 first fetch after release", imem_addr, 32'd0);
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         #1 check(k == 1 ? "R1 second fetch" : "R2 sequential fetch", imem_addr, 32'(4 * k));
      end

      for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
      check("R4 scoreboard drained (watchdog)", 32'(exp_q.size()), 32'd0);

      for (int i = 0; i < 20 && imem_addr != 32'd128; i++) @(negedge clk);
      #1;
      for (int k = 0; k < 6; k++) begin
         check("R8 negative-offset loop", imem_addr, (k % 2 == 0) ? 32'd128 : 32'd132);
         @(negedge clk);
         #1;
      end
      check("R4 no stray store", 32'(exp_q.size()), 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule